// File: doc/BRIEF.md
# Serial Clock-Chip Slave

This block is the slave end of a bit-banged link to a real-time clock and a small parameter memory. The host owns a byte-wide control register. Each write to it can carry a session-enable bit, a serial clock bit and a data bit. The slave watches successive writes. When the clock bit falls while the enable bit is set, it takes in one bit. A complete exchange is sixteen such edges. The first eight edges carry a command byte and the last eight carry a data byte. Both bytes travel most-significant bit first.

For a read command, the slave overrides the data bit in the stored control byte during the data phase. It also collects the returned bits in a readback register that the host can inspect once the exchange is over. The returned byte comes from one of four sources:

- the parameter memory;
- a status byte;
- a fixed configuration byte;
- one of the packed-BCD time fields supplied on input ports.

Write commands fill a memory byte or clear status flags. A flag-clear command also emits a one-cycle strobe that tells the interrupt controller to drop the matching source. Dropping the enable bit abandons the exchange at any point.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset, hostOut is 0x00, readback is 0x00 and irqClr is 0. The status byte is 0x90. Memory byte i equals bits [8i+7:8i] of RAM_INIT.
- R2: In hostIn, bit 0 is enable, bit 1 is serial clock and bit 2 is data. A bit is taken only on a host write that has bit 1 = 0 and bit 0 = 1, when the previous host write had bit 1 = 1. Every host write is stored into hostOut with bits 7:3 and 1:0 unchanged.
- R3: The first eight taken bits form the command byte, MSB first.
- R4: For a command in 0x00..0x1F, data-phase edge k (k = 0..7) sets hostOut bit 2 to bit 7−k of memory byte [command]. The same bit is shifted into the LSB of readback, so readback holds the whole byte after edge 7.
- R5: Command 0x30 returns the status byte and command 0x31 returns the configuration byte CFG_BYTE, in the same way as R4.
- R6: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return the BCD inputs tSec, tMin, tHour, tDay, tMonth and tYear. Any other command in 0x20..0x2F returns 0x00.
- R7: At the sixteenth edge, a command in 0x80..0x9F writes the received data byte into memory byte [command − 0x80].
- R8: At the sixteenth edge, command 0xB1 with data bit 2 set clears status bits 4 and 3. It also drives irqClr high for exactly one cycle. If data bit 2 is clear, nothing changes.
- R9: A host write with bit 0 = 0 abandons the exchange. Phase, command and data are cleared, and a partly sent write does not change memory.
- R10: Edges after the sixteenth are ignored until enable goes low. They do not change readback, and hostOut bit 2 follows the host's bit.
- R11: For commands that are not reads (not 0x00..0x31), hostOut bit 2 follows the host's bit and readback is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host writes the control byte this cycle |
| hostIn | input | 8 | Control byte written by the host |
| tSec | input | 8 | Seconds, BCD |
| tMin | input | 8 | Minutes, BCD |
| tHour | input | 8 | Hours, BCD |
| tDay | input | 8 | Day of month, BCD |
| tMonth | input | 8 | Month (1-based), BCD |
| tYear | input | 8 | Two-digit year, BCD |
| hostOut | output | 8 | Stored control byte, with the returned data bit |
| readback | output | 8 | Shift register of returned bits |
| irqClr | output | 1 | One-cycle interrupt-clear strobe |

## Verification
Every result is registered once. hostOut, readback and memory or status changes therefore appear at the clock edge that accepts the host write. The host write drives the inputs at a falling edge and holds them through one rising edge. The bench samples at the next falling edge, one cycle after the stimulus. At that sample point irqClr is high, and the bench then waits one further falling edge to confirm it has dropped. Memory and status changes are confirmed later through ordinary read exchanges, and the expected values come from a bench-side model.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;

  localparam logic [7:0] CMD_TIME_BASE = 8'h20;
  localparam logic [7:0] CMD_STATUS    = 8'h30;
  localparam logic [7:0] CMD_CONFIG    = 8'h31;
  localparam logic [7:0] CMD_WR_BASE   = 8'h80;
  localparam logic [7:0] CMD_CLEAR     = 8'hB1;
  localparam logic [7:0] CLEAR_FLAGS   = 8'h18;

  typedef struct packed {
    logic       abort;
    logic       shiftCmd;
    logic       shiftVal;
    logic       commit;
    logic [2:0] bitIdx;
  } rtcStrobe_t;

endpackage

// File: rtl/rtc_serial_ctrl.sv
module rtc_serial_ctrl
  import rtc_serial_pkg::*;
#(
  parameter int PHASE_LAST = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWe,
  input  logic [7:0] hostIn,
  output rtcStrobe_t strb
);
  localparam int PW = $clog2(PHASE_LAST + 1);
  localparam logic [PW-1:0] LAST = PW'(PHASE_LAST);
  localparam logic [PW-1:0] HALF = PW'(PHASE_LAST / 2);

  logic          sclkPrev;
  logic [PW-1:0] phase;
  logic          fallEdge;
  logic          active;

  assign fallEdge      = hostWe && hostIn[0] && sclkPrev && !hostIn[1];
  assign active        = fallEdge && (phase < LAST);
  assign strb.abort    = hostWe && !hostIn[0];
  assign strb.shiftCmd = active && (phase < HALF);
  assign strb.shiftVal = active && (phase >= HALF);
  assign strb.commit   = active && (phase == LAST - 1'b1);
  assign strb.bitIdx   = phase[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      phase    <= '0;
    end else begin
      if (hostWe) sclkPrev <= hostIn[1];
      if (strb.abort) phase <= '0;
      else if (active) phase <= phase + 1'b1;
    end
  end

  // R10
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);

  // R9
  abort_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.abort |=> phase == '0);

endmodule

// File: rtl/rtc_serial_data.sv
module rtc_serial_data
  import rtc_serial_pkg::*;
#(
  parameter int                   RAM_BYTES   = 32,
  parameter logic [RAM_BYTES*8-1:0] RAM_INIT  = '0,
  parameter logic [7:0]           STATUS_INIT = 8'h90,
  parameter logic [7:0]           CFG_BYTE    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWe,
  input  logic [7:0] hostIn,
  input  rtcStrobe_t strb,
  input  logic [7:0] tSec,
  input  logic [7:0] tMin,
  input  logic [7:0] tHour,
  input  logic [7:0] tDay,
  input  logic [7:0] tMonth,
  input  logic [7:0] tYear,
  output logic [7:0] hostOut,
  output logic [7:0] readback,
  output logic       irqClr
);
  localparam int AW = $clog2(RAM_BYTES);
  localparam logic [7:0] RAM_TOP = 8'(RAM_BYTES);
  localparam logic [7:0] WR_TOP  = 8'(128 + RAM_BYTES);

  logic [7:0]    ram [RAM_BYTES];
  logic [7:0]    cmdReg, valReg, statusReg, rbReg, hostReg;
  logic          irqReg;
  logic [7:0]    srcByte;
  logic          srcValid;
  logic          selBit, outBit;
  logic [7:0]    newVal;
  logic          isRamWr, clrHit;
  logic [AW-1:0] wrIdx;

  always_comb begin
    srcByte  = 8'h00;
    srcValid = 1'b1;
    if (cmdReg < RAM_TOP) begin
      srcByte = ram[cmdReg[AW-1:0]];
    end else if (cmdReg[7:4] == CMD_TIME_BASE[7:4]) begin
      case (cmdReg[3:0])
        4'h0:    srcByte = tSec;
        4'h1:    srcByte = tMin;
        4'h2:    srcByte = tHour;
        4'h4:    srcByte = tDay;
        4'h5:    srcByte = tMonth;
        4'h6:    srcByte = tYear;
        default: srcByte = 8'h00;
      endcase
    end else if (cmdReg == CMD_STATUS) begin
      srcByte = statusReg;
    end else if (cmdReg == CMD_CONFIG) begin
      srcByte = CFG_BYTE;
    end else begin
      srcValid = 1'b0;
    end
  end

  assign selBit  = srcByte[3'd7 - strb.bitIdx];
  assign outBit  = (strb.shiftVal && srcValid) ? selBit : hostIn[2];
  assign newVal  = {valReg[6:0], hostIn[2]};
  assign isRamWr = (cmdReg >= CMD_WR_BASE) && (cmdReg < WR_TOP);
  assign wrIdx   = AW'(cmdReg - CMD_WR_BASE);
  assign clrHit  = strb.commit && (cmdReg == CMD_CLEAR) && newVal[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= RAM_INIT[8*i +: 8];
      cmdReg    <= 8'h00;
      valReg    <= 8'h00;
      statusReg <= STATUS_INIT;
      rbReg     <= 8'h00;
      hostReg   <= 8'h00;
      irqReg    <= 1'b0;
    end else begin
      irqReg <= clrHit;
      if (hostWe) hostReg <= {hostIn[7:3], outBit, hostIn[1:0]};
      if (strb.abort) begin
        cmdReg <= 8'h00;
        valReg <= 8'h00;
      end else begin
        if (strb.shiftCmd) cmdReg <= {cmdReg[6:0], hostIn[2]};
        if (strb.shiftVal) valReg <= newVal;
      end
      if (strb.shiftVal && srcValid) rbReg <= {rbReg[6:0], selBit};
      if (strb.commit && isRamWr) ram[wrIdx] <= newVal;
      if (clrHit) statusReg <= statusReg & ~CLEAR_FLAGS;
    end
  end

  assign hostOut  = hostReg;
  assign readback = rbReg;
  assign irqClr   = irqReg;

  // R8
  irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqClr |-> statusReg[4:3] == 2'b00);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqClr |=> !irqClr);

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.abort |=> (cmdReg == 8'h00) && (valReg == 8'h00));

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_serial_pkg::*;
#(
  parameter int                     RAM_BYTES   = 32,
  parameter logic [RAM_BYTES*8-1:0] RAM_INIT    = '0,
  parameter logic [7:0]             STATUS_INIT = 8'h90,
  parameter logic [7:0]             CFG_BYTE    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWe,
  input  logic [7:0] hostIn,
  input  logic [7:0] tSec,
  input  logic [7:0] tMin,
  input  logic [7:0] tHour,
  input  logic [7:0] tDay,
  input  logic [7:0] tMonth,
  input  logic [7:0] tYear,
  output logic [7:0] hostOut,
  output logic [7:0] readback,
  output logic       irqClr
);
  rtcStrobe_t strb;

  rtc_serial_ctrl #(.PHASE_LAST(16)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWe(hostWe), .hostIn(hostIn), .strb(strb)
  );

  rtc_serial_data #(
    .RAM_BYTES(RAM_BYTES), .RAM_INIT(RAM_INIT),
    .STATUS_INIT(STATUS_INIT), .CFG_BYTE(CFG_BYTE)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .hostWe(hostWe), .hostIn(hostIn), .strb(strb),
    .tSec(tSec), .tMin(tMin), .tHour(tHour), .tDay(tDay),
    .tMonth(tMonth), .tYear(tYear),
    .hostOut(hostOut), .readback(readback), .irqClr(irqClr)
  );

endmodule

// File: tb/rtc_serial_slave_test.sv
module rtc_serial_slave_test;
  localparam logic [255:0] INIT =
    256'h0123456789ABCDEF_FEDCBA9876543210_A55A3CC30FF0F00F_13579BDF2468ACE0;
  localparam logic [7:0] CFG = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostWe = 1'b0;
  logic [7:0] hostIn = 8'h00;
  logic [7:0] tSec = 0, tMin = 0, tHour = 0, tDay = 0, tMonth = 0, tYear = 0;
  logic [7:0] hostOut, readback;
  logic irqClr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mRam [32];
  logic [7:0] mStatus = 8'h90;
  logic [7:0] mRb = 8'h00;

  always #5 clk = ~clk;

  rtc_serial_slave #(.RAM_BYTES(32), .RAM_INIT(INIT), .STATUS_INIT(8'h90),
                     .CFG_BYTE(CFG)) uut (
    .clk(clk), .rst_n(rst_n), .hostWe(hostWe), .hostIn(hostIn),
    .tSec(tSec), .tMin(tMin), .tHour(tHour), .tDay(tDay),
    .tMonth(tMonth), .tYear(tYear),
    .hostOut(hostOut), .readback(readback), .irqClr(irqClr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] toBcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic bit isRead(input logic [7:0] c);
    return c <= 8'h31;
  endfunction

  function automatic logic [7:0] expByte(input logic [7:0] c);
    if (c < 8'h20) return mRam[c[4:0]];
    if (c == 8'h30) return mStatus;
    if (c == 8'h31) return CFG;
    case (c)
      8'h20: return tSec;
      8'h21: return tMin;
      8'h22: return tHour;
      8'h24: return tDay;
      8'h25: return tMonth;
      8'h26: return tYear;
      default: return 8'h00;
    endcase
  endfunction

  // one host write: driven at a falling edge, held across one rising edge
  task automatic hostWrite(input logic [7:0] v);
    @(negedge clk);
    hostWe = 1'b1;
    hostIn = v;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    hostWrite({5'b0, b, 1'b1, 1'b1});
    hostWrite({5'b0, b, 1'b0, 1'b1});
  endtask

  // full exchange, enable left high at the end
  task automatic xfer(input logic [7:0] c, input logic [7:0] d, input string tag);
    logic [7:0] e;
    logic expIrq;
    e = expByte(c);
    hostWrite(8'h00);
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = (i < 8) ? c[7-i] : d[15-i];
      sendBit(b);
      if (i >= 8) begin
        if (isRead(c)) check({tag, " data bit"}, 32'(hostOut[2]), 32'(e[15-i]));
        else           check("R11 host bit passes", 32'(hostOut[2]), 32'(b));
      end
    end
    expIrq = (c == 8'hB1) && d[2];
    check("R8 irqClr after commit", 32'(irqClr), 32'(expIrq));
    @(negedge clk);
    check("R8 irqClr one cycle", 32'(irqClr), 32'(0));
    if (isRead(c)) mRb = e;
    check({tag, " readback"}, 32'(readback), 32'(mRb));
    if (c >= 8'h80 && c <= 8'h9F) mRam[c[4:0]] = d;
    if (expIrq) mStatus = mStatus & ~8'h18;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mRam[i] = INIT[8*i +: 8];
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hostOut reset", 32'(hostOut), 32'h00);
    check("R1 readback reset", 32'(readback), 32'h00);
    check("R1 irqClr reset", 32'(irqClr), 32'h0);
    xfer(8'h30, 8'h00, "R1 status reset");
    check("R1 status 0x90", 32'(readback), 32'h90);
    xfer(8'h00, 8'h00, "R1 ram init");
    check("R1 ram byte0", 32'(readback), 32'hE0);
    hostWrite(8'h00);

    // R2: field positions kept in hostOut, falling clock with enable low ignored
    hostWrite(8'hA3);
    check("R2 store byte", 32'(hostOut), 32'hA3);
    hostWrite(8'hF8);
    check("R2 store byte", 32'(hostOut), 32'hFC & 32'hF8 | 32'h00);

    // R3/R4 directed reads
    xfer(8'h1F, 8'hFF, "R4 ram read top");
    xfer(8'h31, 8'h00, "R5 config read");
    tSec = toBcd(59); tMin = toBcd(7); tHour = toBcd(23);
    tDay = toBcd(31); tMonth = toBcd(12); tYear = toBcd(99);
    xfer(8'h26, 8'h00, "R6 year read");
    xfer(8'h23, 8'h00, "R6 unused time code");
    check("R6 unused time zero", 32'(readback), 32'h00);
    hostWrite(8'h00);

    // R7 write then read back
    xfer(8'h83, 8'h3C, "R7 ram write");
    xfer(8'h03, 8'h00, "R7 ram verify");
    check("R7 written byte", 32'(readback), 32'h3C);
    hostWrite(8'h00);

    // R8 no-op clear then real clear
    xfer(8'hB1, 8'hFB, "R8 no clear");
    xfer(8'h30, 8'h00, "R8 status kept");
    check("R8 status kept", 32'(readback), 32'h90);
    xfer(8'hB1, 8'h04, "R8 clear");
    xfer(8'h30, 8'h00, "R8 status cleared");
    check("R8 status cleared", 32'(readback), 32'h80);
    hostWrite(8'h00);

    // R9 partial write then abort
    hostWrite(8'h00);
    for (int i = 0; i < 12; i++) sendBit((i < 8) ? 1'((8'h85 >> (7 - i)) & 1) : 1'b1);
    hostWrite(8'h00);
    xfer(8'h05, 8'h00, "R9 abort no write");
    check("R9 ram untouched", 32'(readback), 32'(INIT[8*5 +: 8]));

    // R10 extra edges ignored (enable still high)
    for (int i = 0; i < 3; i++) begin
      sendBit(1'b1);
      check("R10 host bit passes", 32'(hostOut[2]), 32'h1);
      check("R10 readback held", 32'(readback), 32'(mRb));
    end
    hostWrite(8'h00);

    // R11 non-read command
    xfer(8'h47, 8'hA5, "R11 other cmd");
    hostWrite(8'h00);

    // constrained random exchanges
    for (int n = 0; n < 60; n++) begin
      logic [7:0] c, d;
      int k;
      k = int'($urandom % 7);
      d = 8'($urandom);
      case (k)
        0: c = {3'b000, 5'($urandom)};
        1: c = {3'b100, 5'($urandom)};
        2: c = {4'h2, 4'($urandom)};
        3: c = 8'h30;
        4: c = 8'h31;
        5: c = 8'hB1;
        default: c = {2'b01, 6'($urandom)};
      endcase
      tSec = toBcd(int'($urandom % 60)); tMin = toBcd(int'($urandom % 60));
      tHour = toBcd(int'($urandom % 24)); tDay = toBcd(1 + int'($urandom % 31));
      tMonth = toBcd(1 + int'($urandom % 12)); tYear = toBcd(int'($urandom % 100));
      xfer(c, d, "R3 R4 R5 R6 R7 random");
      hostWrite(8'h00);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule